// File: doc/BRIEF.md
# Receive-Buffer Watermark Pause Controller

This block decides when the local station asks its link partner to stop sending. It tracks how many receive descriptors are free and how many complete frames are still waiting for software. From these it raises or drops a registered pause-request level, which goes to a MAC transmitter. The request uses hysteresis between a low and a high free-descriptor mark, so it does not toggle on every descriptor. The low mark is one third of the total descriptor count, rounded down, and the high mark is twice the low mark.

Each link update strobe carries the negotiated link state. On that strobe the block works out whether flow control may run on the link. This requires the local enable, a full-duplex link and a partner that advertises symmetric pause. The block also drives the local pause advertisement bits from the local enable.

When the link is down, flow control is not active, or the backlog is empty, the request is held low.

Top module: `rxwm_pause_ctrl`

## Requirements
- R1: With DESC_TOTAL descriptors, the low mark is DESC_TOTAL/3 (integer division) and the high mark is twice the low mark. A free count exactly equal to either mark counts as between the marks.
- R2: When flow control is active, the link is up, at least one frame is pending and the free count is below the low mark, pause_req is 1.
- R3: A free count above the high mark drives pause_req to 0.
- R4: A pending-frame count of zero drives pause_req to 0, whatever the free count.
- R5: With flow control active, frames pending and the free count between the marks (inclusive), pause_req keeps its previous value.
- R6: On link_upd with link_up=1, the partner counts as pause-capable only if full_duplex=1 and peer_sym_pause=1. Changes to full_duplex or peer_sym_pause without link_upd have no effect.
- R7: fc_active becomes fc_enable AND partner-capable on each link_upd. While fc_active is 0, pause_req is 0.
- R8: adv_sym_pause and adv_asym_pause both equal fc_enable, one cycle later.
- R9: On cnt_upd, the free count is sampled as DESC_TOTAL minus sw_owned, saturating at 0 when sw_owned exceeds DESC_TOTAL, and pend_frames is sampled with it. pause_req reflects a sample two clock edges after the strobe. Inputs that change without a strobe have no effect.
- R10: A link_upd with link_up=0 clears fc_active and forces pause_req to 0.
- R11: After reset, pause_req, fc_active and both advertisement bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_enable | input | 1 | Local flow-control enable |
| link_upd | input | 1 | Link state update strobe |
| link_up | input | 1 | Link is up (valid with link_upd) |
| full_duplex | input | 1 | Negotiated full duplex (valid with link_upd) |
| peer_sym_pause | input | 1 | Partner symmetric pause bit (valid with link_upd) |
| cnt_upd | input | 1 | Descriptor count update strobe |
| sw_owned | input | CNT_W | Descriptors currently owned by software |
| pend_frames | input | PEND_W | Complete frames still pending |
| adv_sym_pause | output | 1 | Local symmetric pause advertisement |
| adv_asym_pause | output | 1 | Local asymmetric pause advertisement |
| fc_active | output | 1 | Flow control active for this link; 0 means the MAC flow configuration is cleared |
| pause_req | output | 1 | Pause request level to the MAC transmitter |

## Verification
The hardest state to reach is the hold band. There, the request's value depends on history: the free count must first go below the low mark or above the high mark, and then settle between the marks while frames stay pending. Directed steps walk the free count down through the low mark, across both exact mark values and up past the high mark. Random steps then mix count updates, link updates and enable changes, checking against a bench model that carries the previous request. Further directed steps change the inputs without their strobes, take the link down while a pause is asserted, and write an owned count larger than the descriptor total.

// File: rtl/rxwm_pkg.sv
package rxwm_pkg;

  // Resolved link state held between link updates
  typedef struct packed {
    logic up;
    logic capable;
    logic active;
  } link_res_t;

  function automatic int unsigned low_mark(int unsigned total);
    return total / 3;
  endfunction

  function automatic int unsigned high_mark(int unsigned total);
    return 2 * low_mark(total);
  endfunction

  // Partner may be paused only on a full-duplex link with symmetric pause
  function automatic logic partner_capable(logic fdx, logic sym);
    return fdx & sym;
  endfunction

endpackage

// File: rtl/rxwm_link_resolver.sv
module rxwm_link_resolver
  import rxwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fc_enable,
  input  logic link_upd,
  input  logic link_up,
  input  logic full_duplex,
  input  logic peer_sym_pause,
  output logic link_up_q,
  output logic peer_capable,
  output logic fc_active,
  output logic adv_sym_pause,
  output logic adv_asym_pause
);
  link_res_t res_q;
  link_res_t res_d;

  always_comb begin
    res_d = res_q;
    if (link_upd) begin
      res_d.up      = link_up;
      res_d.capable = link_up & partner_capable(full_duplex, peer_sym_pause);
      res_d.active  = link_up & fc_enable & res_d.capable;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q          <= '0;
      adv_sym_pause  <= 1'b0;
      adv_asym_pause <= 1'b0;
    end else begin
      res_q          <= res_d;
      adv_sym_pause  <= fc_enable;
      adv_asym_pause <= fc_enable;
    end
  end

  assign link_up_q    = res_q.up;
  assign peer_capable = res_q.capable;
  assign fc_active    = res_q.active;
endmodule

// File: rtl/rxwm_level_sampler.sv
module rxwm_level_sampler #(
  parameter int unsigned DESC_TOTAL = 30,
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned PEND_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_upd,
  input  logic [CNT_W-1:0]  sw_owned,
  input  logic [PEND_W-1:0] pend_frames,
  output logic [CNT_W-1:0]  free_cnt,
  output logic [PEND_W-1:0] pend_cnt
);
  localparam logic [CNT_W-1:0] TOTAL_V = CNT_W'(DESC_TOTAL);

  logic [CNT_W-1:0] free_d;

  always_comb begin
    if (sw_owned > TOTAL_V) free_d = '0;
    else                    free_d = TOTAL_V - sw_owned;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_cnt <= TOTAL_V;
      pend_cnt <= '0;
    end else if (cnt_upd) begin
      free_cnt <= free_d;
      pend_cnt <= pend_frames;
    end
  end
endmodule

// File: rtl/rxwm_hysteresis.sv
module rxwm_hysteresis
  import rxwm_pkg::*;
#(
  parameter int unsigned DESC_TOTAL = 30,
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned PEND_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up_q,
  input  logic              fc_active,
  input  logic [CNT_W-1:0]  free_cnt,
  input  logic [PEND_W-1:0] pend_cnt,
  output logic              below_low,
  output logic              above_high,
  output logic              none_pending,
  output logic              pause_req
);
  localparam int unsigned      LOW    = low_mark(DESC_TOTAL);
  localparam int unsigned      HIGH   = high_mark(DESC_TOTAL);
  localparam logic [CNT_W-1:0] LOW_V  = CNT_W'(LOW);
  localparam logic [CNT_W-1:0] HIGH_V = CNT_W'(HIGH);

  logic armed;

  always_comb begin
    below_low    = free_cnt < LOW_V;
    above_high   = free_cnt > HIGH_V;
    none_pending = (pend_cnt == '0);
    armed        = link_up_q & fc_active & ~none_pending;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          pause_req <= 1'b0;
    else if (!armed)     pause_req <= 1'b0;
    else if (below_low)  pause_req <= 1'b1;
    else if (above_high) pause_req <= 1'b0;
  end
endmodule

// File: rtl/rxwm_pause_ctrl.sv
module rxwm_pause_ctrl #(
  parameter int unsigned DESC_TOTAL = 30,
  parameter int unsigned PEND_W     = 8,
  localparam int unsigned CNT_W     = $clog2(DESC_TOTAL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fc_enable,
  input  logic              link_upd,
  input  logic              link_up,
  input  logic              full_duplex,
  input  logic              peer_sym_pause,
  input  logic              cnt_upd,
  input  logic [CNT_W-1:0]  sw_owned,
  input  logic [PEND_W-1:0] pend_frames,
  output logic              adv_sym_pause,
  output logic              adv_asym_pause,
  output logic              fc_active,
  output logic              pause_req
);
  logic              link_up_q;
  logic              peer_capable;
  logic [CNT_W-1:0]  free_cnt;
  logic [PEND_W-1:0] pend_cnt;
  logic              below_low;
  logic              above_high;
  logic              none_pending;

  rxwm_link_resolver link_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .fc_enable      (fc_enable),
    .link_upd       (link_upd),
    .link_up        (link_up),
    .full_duplex    (full_duplex),
    .peer_sym_pause (peer_sym_pause),
    .link_up_q      (link_up_q),
    .peer_capable   (peer_capable),
    .fc_active      (fc_active),
    .adv_sym_pause  (adv_sym_pause),
    .adv_asym_pause (adv_asym_pause)
  );

  rxwm_level_sampler #(
    .DESC_TOTAL (DESC_TOTAL),
    .CNT_W      (CNT_W),
    .PEND_W     (PEND_W)
  ) samp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_upd     (cnt_upd),
    .sw_owned    (sw_owned),
    .pend_frames (pend_frames),
    .free_cnt    (free_cnt),
    .pend_cnt    (pend_cnt)
  );

  rxwm_hysteresis #(
    .DESC_TOTAL (DESC_TOTAL),
    .CNT_W      (CNT_W),
    .PEND_W     (PEND_W)
  ) hyst_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_up_q    (link_up_q),
    .fc_active    (fc_active),
    .free_cnt     (free_cnt),
    .pend_cnt     (pend_cnt),
    .below_low    (below_low),
    .above_high   (above_high),
    .none_pending (none_pending),
    .pause_req    (pause_req)
  );
endmodule

// File: rtl/rxwm_pause_chk.sv
module rxwm_pause_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fc_enable,
  input logic             link_upd,
  input logic             link_up,
  input logic             full_duplex,
  input logic             peer_sym_pause,
  input logic             cnt_upd,
  input logic             adv_sym_pause,
  input logic             adv_asym_pause,
  input logic             fc_active,
  input logic             pause_req,
  input logic             link_up_q,
  input logic             peer_capable,
  input logic [CNT_W-1:0] free_cnt,
  input logic             below_low,
  input logic             above_high,
  input logic             none_pending
);
  assert_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up_q && fc_active && !none_pending && below_low) |=> pause_req);

  assert_drop_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    above_high |=> !pause_req);

  assert_drop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    none_pending |=> !pause_req);

  assert_hold_band_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up_q && fc_active && !none_pending && !below_low && !above_high)
      |=> (pause_req == $past(pause_req)));

  assert_partner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (link_upd && link_up) |=> (peer_capable == $past(full_duplex && peer_sym_pause)));

  assert_inactive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_active |=> !pause_req);

  assert_active_res_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_upd |=> (fc_active == $past(link_up && fc_enable && full_duplex && peer_sym_pause)));

  assert_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (adv_sym_pause == $past(fc_enable) && adv_asym_pause == $past(fc_enable)));

  assert_sample_only_on_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_upd |=> $stable(free_cnt));

  assert_link_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (link_upd && !link_up) |=> (!fc_active && !link_up_q));

  assert_down_no_pause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up_q |=> !pause_req);
endmodule

bind rxwm_pause_ctrl rxwm_pause_chk #(.CNT_W(CNT_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .fc_enable      (fc_enable),
  .link_upd       (link_upd),
  .link_up        (link_up),
  .full_duplex    (full_duplex),
  .peer_sym_pause (peer_sym_pause),
  .cnt_upd        (cnt_upd),
  .adv_sym_pause  (adv_sym_pause),
  .adv_asym_pause (adv_asym_pause),
  .fc_active      (fc_active),
  .pause_req      (pause_req),
  .link_up_q      (link_up_q),
  .peer_capable   (peer_capable),
  .free_cnt       (free_cnt),
  .below_low      (below_low),
  .above_high     (above_high),
  .none_pending   (none_pending)
);

// File: tb/rxwm_pause_ctrl_tb.sv
`timescale 1ns/1ps
module rxwm_pause_ctrl_tb_top;
  localparam int T  = 30;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fc_enable = 1'b0, link_upd = 1'b0, link_up = 1'b0;
  logic full_duplex = 1'b0, peer_sym_pause = 1'b0, cnt_upd = 1'b0;
  logic [4:0] sw_owned = '0;
  logic [PW-1:0] pend_frames = '0;
  logic adv_sym_pause, adv_asym_pause, fc_active, pause_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model
  int  m_free = T;
  int  m_pend = 0;
  bit  m_up = 0, m_act = 0, m_pause = 0, m_en = 0;

  always #2 clk = ~clk;

  rxwm_pause_ctrl #(.DESC_TOTAL(T), .PEND_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .fc_enable(fc_enable), .link_upd(link_upd),
    .link_up(link_up), .full_duplex(full_duplex), .peer_sym_pause(peer_sym_pause),
    .cnt_upd(cnt_upd), .sw_owned(sw_owned), .pend_frames(pend_frames),
    .adv_sym_pause(adv_sym_pause), .adv_asym_pause(adv_asym_pause),
    .fc_active(fc_active), .pause_req(pause_req)
  );

  function automatic bit model_pause(bit prev, int fr, int pd, bit act, bit up);
    int lo, hi;
    lo = T / 3;
    hi = lo + lo;
    if (!(up && act)) return 1'b0;
    if (pd == 0)      return 1'b0;
    if (fr < lo)      return 1'b1;
    if (fr > hi)      return 1'b0;
    return prev;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(string req);
    check(req, pause_req, m_pause);
    check(req, fc_active, m_act);
    check(req, adv_sym_pause, m_en);
    check(req, adv_asym_pause, m_en);
  endtask

  task automatic do_cnt(int owned, int pend, string req);
    @(negedge clk);
    sw_owned = 5'(owned); pend_frames = PW'(pend); cnt_upd = 1'b1;
    @(negedge clk);
    cnt_upd = 1'b0;
    @(negedge clk);
    m_free  = (owned > T) ? 0 : T - owned;
    m_pend  = pend;
    m_pause = model_pause(m_pause, m_free, m_pend, m_act, m_up);
    check_all(req);
  endtask

  task automatic do_link(bit up, bit fd, bit sym, string req);
    @(negedge clk);
    link_up = up; full_duplex = fd; peer_sym_pause = sym; link_upd = 1'b1;
    @(negedge clk);
    link_upd = 1'b0;
    @(negedge clk);
    m_up    = up;
    m_act   = up && fd && sym && m_en;
    m_pause = model_pause(m_pause, m_free, m_pend, m_act, m_up);
    check_all(req);
  endtask

  task automatic set_en(bit en, string req);
    @(negedge clk);
    fc_enable = en;
    @(negedge clk);
    m_en = en;
    check_all(req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R11 reset");

    set_en(1'b1, "R8 adv on");
    do_link(1'b1, 1'b1, 1'b1, "R6 R7 capable link");
    do_cnt(21, 3, "R2 R1 free 9 below low");
    do_cnt(20, 3, "R5 R1 free at low mark holds");
    do_cnt(10, 3, "R5 R1 free at high mark holds");
    do_cnt(9, 3, "R3 R1 free 21 above high");
    do_cnt(15, 3, "R5 middle holds 0");
    do_cnt(25, 2, "R2 free 5");
    do_cnt(25, 0, "R4 no pending");
    do_cnt(31, 1, "R9 owned above total saturates");

    // inputs without strobe are ignored
    @(negedge clk);
    sw_owned = '0; pend_frames = '0;
    repeat (3) @(negedge clk);
    check_all("R9 count change without strobe");

    do_link(1'b1, 1'b0, 1'b1, "R6 half duplex not capable");
    do_link(1'b1, 1'b1, 1'b1, "R6 R7 reenabled");
    @(negedge clk);
    full_duplex = 1'b0; peer_sym_pause = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R6 link change without strobe");
    do_link(1'b1, 1'b1, 1'b0, "R6 no symmetric pause");
    do_link(1'b1, 1'b1, 1'b1, "R7 back active");
    do_link(1'b0, 1'b1, 1'b1, "R10 link down");
    set_en(1'b0, "R8 adv off");
    do_link(1'b1, 1'b1, 1'b1, "R7 local disable");
    set_en(1'b1, "R8 adv on again");
    do_link(1'b1, 1'b1, 1'b1, "R7 active again");

    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 8);
      if (op < 5)
        do_cnt(int'($urandom % 32), int'($urandom % 3), "R1 R2 R3 R4 R5 random count");
      else if (op < 7)
        do_link(($urandom % 5) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
                "R6 R7 R10 random link");
      else
        set_en(($urandom % 4) != 0, "R8 random enable");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule